// File: doc/BRIEF.md
# Rotor Cipher Command Sequencer

This block is the front-end controller that sits in front of a three-slot rotor cipher datapath. On each rising clock edge it samples an 8-bit command word. The word holds a 3-bit opcode and a 5-bit operand. The block decodes the word and rejects operands that are out of range. It gives each repeated slot-loading command its own slot counter, so that successive loads fill slots 0, 1 and 2 (rightmost first). It drives single-cycle load strobes towards the datapath.

A plugboard entry is written in two steps. The first command latches a source letter. The next plug-data command then issues one table write. An encipher command hands a letter to the datapath, which answers after a variable number of cycles. The sequencer holds its ready flag low until that answer arrives, then captures the result and shows it on a 7-segment output. A reset command, or the synchronous reset pin, clears the datapath and reloads the default rotor choice. Other commands do not drop ready, so the controller can accept them on consecutive cycles.

Top module: `cipher_cmd_seq`

## Requirements
- R1: The command word carries the opcode in bits 7:5 and the operand in bits 4:0. The opcodes are:
    - 0 no-op
    - 1 start position load
    - 2 ring setting load
    - 3 machine reset
    - 4 encipher
    - 5 plug address
    - 6 plug data
    - 7 rotor select
- R2: After rst_n is low, and also one cycle after an accepted reset command, the block does the following:
    - It pulses dp_clear_o for one cycle.
    - In each of the next three cycles it pulses ld_rotor_o, with slot and value 0, then 1, then 2.
    - ready_o is low until the third of these writes. It is high in the same cycle as the third write.
    - result_o and seg_o are 0, all slot counters are cleared, and no plug address is pending.
- R3: Start, ring and rotor loads each have their own slot counter. The counter steps 0, 1, 2 and then wraps to 0. The cycle after an accepted load, the matching strobe is high for one cycle. It carries the counter value on ld_slot_o and the operand on ld_val_o.
- R4: Some operands are out of range: above 25 for a letter command, or above 4 for rotor select. A command with such an operand is dropped completely. It gives no strobe, does not advance a counter and captures no address.
- R5: Plug address stores its operand as pending. The next plug data command gives one plug_we_o pulse, with the stored address and the new operand, and clears the pending state. A plug data command with nothing pending produces no write.
- R6: An accepted encipher command pulses enc_start_o one cycle later, with the letter on enc_char_o, and ready_o falls in that same cycle. The block captures enc_result_i in the cycle that enc_done_i is high. In the next cycle ready_o is high and result_o holds the captured value.
- R7: Words presented while ready_o is low have no effect: no strobe, no counter step and no pending change.
- R8: A no-op produces no strobe, keeps ready_o high and changes no state.
- R9: seg_o is 0 until the first encipher result arrives after reset. After that it shows the result letter's glyph, with bit 0 as segment a and bit 6 as segment g. For example, letter 0 (A) shows 0x77 and letter 25 (Z) shows 0x5B.
- R10: Load, plug and no-op commands keep ready_o high, so the block accepts them on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_word_i | input | 8 | Opcode (7:5) and operand (4:0) |
| ready_o | output | 1 | Next command word may be sampled |
| result_o | output | 5 | Last encipher result |
| seg_o | output | 7 | Segment pattern of the result (bit0=a) |
| dp_clear_o | output | 1 | Datapath clear pulse |
| ld_pos_o | output | 1 | Start position load strobe |
| ld_ring_o | output | 1 | Ring setting load strobe |
| ld_rotor_o | output | 1 | Rotor type load strobe |
| ld_slot_o | output | 2 | Slot addressed by a load strobe |
| ld_val_o | output | 5 | Value for a load strobe |
| plug_we_o | output | 1 | Plugboard table write strobe |
| plug_addr_o | output | 5 | Plugboard write address |
| plug_data_o | output | 5 | Plugboard write data |
| enc_start_o | output | 1 | Encipher start pulse |
| enc_char_o | output | 5 | Letter to encipher |
| enc_done_i | input | 1 | Datapath result valid |
| enc_result_i | input | 5 | Enciphered letter |

## Verification
The assertions check several properties on every cycle:
- At most one datapath strobe fires at a time.
- Every load value and plug field stays within the letter or rotor range.
- Slot counters never leave 0 to 2 and wrap after slot 2.
- An encipher start always comes with ready low.
- No strobe follows a cycle spent waiting on the datapath.
- The result register takes the datapath's value on completion.

The bench scenarios show the behaviour that depends on history:
- The exact order of the slots across mixed commands.
- The two-step plug protocol, including a data command with no address before it.
- That words sent while busy are really lost.
- The blank display before the first result.
- The full clear-and-reload sequence after both kinds of reset.

// File: rtl/cipher_seq_pkg.sv
// Package: shared opcode encoding for the cipher command sequencer.
// Assumes a 3-bit opcode field at the top of every command word.
package cipher_seq_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 3'd0,
        OP_POS   = 3'd1,
        OP_RING  = 3'd2,
        OP_CLEAR = 3'd3,
        OP_ENC   = 3'd4,
        OP_PADDR = 3'd5,
        OP_PDATA = 3'd6,
        OP_ROTOR = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        S_INIT = 2'd0,
        S_IDLE = 2'd1,
        S_WAIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cmd_decode.sv
// Splits a command word into opcode and operand and flags whether the
// operand is in range for that opcode. Purely combinational.
// Assumes the opcode sits above a SYM_W-bit operand.
module cmd_decode
    import cipher_seq_pkg::*;
#(
    parameter int SYM_W         = 5,
    parameter int N_LETTERS     = 26,
    parameter int N_ROTOR_TYPES = 5,
    localparam int WORD_W       = OP_W + SYM_W
) (
    input  logic [WORD_W-1:0] word_i,
    output op_e               op_o,
    output logic [SYM_W-1:0]  data_o,
    output logic              ok_o
);
    localparam logic [SYM_W-1:0] LET_MAX = SYM_W'(N_LETTERS - 1);
    localparam logic [SYM_W-1:0] ROT_MAX = SYM_W'(N_ROTOR_TYPES - 1);

    // Field split and per-opcode operand range check.
    always_comb begin
        op_o   = op_e'(word_i[WORD_W-1:SYM_W]);
        data_o = word_i[SYM_W-1:0];
        unique case (op_o)
            OP_NOP:   ok_o = 1'b0;
            OP_CLEAR: ok_o = 1'b1;
            OP_ROTOR: ok_o = (data_o <= ROT_MAX);
            default:  ok_o = (data_o <= LET_MAX);
        endcase
    end
endmodule

// File: rtl/slot_counters.sv
// One wrapping slot counter for each repeated load command. Each counter
// advances on its own increment input and wraps from the last slot to 0.
// Assumes increments are single-cycle and that clr takes priority.
module slot_counters #(
    parameter int N_SLOTS = 3,
    parameter int N_CNT   = 3,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic [N_CNT-1:0]             inc_i,
    output logic [N_CNT-1:0][SLOT_W-1:0] slot_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N_SLOTS - 1);

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        logic [SLOT_W-1:0] cnt;

        // Step this counter on its increment, wrap after the last slot.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i)
                cnt <= '0;
            else if (inc_i[g])
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end

        assign slot_o[g] = cnt;

        a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= LAST);
        a_r3_slot_wraps: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_i[g] && !clr_i && cnt == LAST) |=> (cnt == '0));
    end
endmodule

// File: rtl/glyph_rom.sv
// Maps a letter index to a 7-segment pattern, with bit 0 as segment a and
// bit 6 as segment g. Indices past the alphabet give a blank pattern.
module glyph_rom #(
    parameter int SYM_W = 5
) (
    input  logic [SYM_W-1:0] sym_i,
    output logic [6:0]       seg_o
);
    // Fixed glyph lookup.
    always_comb begin
        case (sym_i)
            SYM_W'(0):  seg_o = 7'h77;
            SYM_W'(1):  seg_o = 7'h7C;
            SYM_W'(2):  seg_o = 7'h39;
            SYM_W'(3):  seg_o = 7'h5E;
            SYM_W'(4):  seg_o = 7'h79;
            SYM_W'(5):  seg_o = 7'h71;
            SYM_W'(6):  seg_o = 7'h3D;
            SYM_W'(7):  seg_o = 7'h76;
            SYM_W'(8):  seg_o = 7'h06;
            SYM_W'(9):  seg_o = 7'h1E;
            SYM_W'(10): seg_o = 7'h75;
            SYM_W'(11): seg_o = 7'h38;
            SYM_W'(12): seg_o = 7'h37;
            SYM_W'(13): seg_o = 7'h54;
            SYM_W'(14): seg_o = 7'h3F;
            SYM_W'(15): seg_o = 7'h73;
            SYM_W'(16): seg_o = 7'h67;
            SYM_W'(17): seg_o = 7'h50;
            SYM_W'(18): seg_o = 7'h6D;
            SYM_W'(19): seg_o = 7'h78;
            SYM_W'(20): seg_o = 7'h3E;
            SYM_W'(21): seg_o = 7'h1C;
            SYM_W'(22): seg_o = 7'h2A;
            SYM_W'(23): seg_o = 7'h49;
            SYM_W'(24): seg_o = 7'h6E;
            SYM_W'(25): seg_o = 7'h5B;
            default:    seg_o = 7'h00;
        endcase
    end
endmodule

// File: rtl/cipher_cmd_seq.sv
// Top-level command sequencer for a three-slot rotor cipher datapath.
// Samples one command word per cycle while ready, and issues registered
// single-cycle strobes to the datapath. Waits on the datapath's done flag
// for encipher operations, and replays the default rotor choice after
// any reset.
// Assumes enc_done_i comes at least one cycle after enc_start_o and is
// high for only one cycle.
module cipher_cmd_seq
    import cipher_seq_pkg::*;
#(
    parameter int SYM_W         = 5,
    parameter int N_LETTERS     = 26,
    parameter int N_ROTOR_TYPES = 5,
    parameter int N_SLOTS       = 3,
    localparam int SLOT_W       = $clog2(N_SLOTS),
    localparam int WORD_W       = OP_W + SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cmd_word_i,
    output logic              ready_o,
    output logic [SYM_W-1:0]  result_o,
    output logic [6:0]        seg_o,
    output logic              dp_clear_o,
    output logic              ld_pos_o,
    output logic              ld_ring_o,
    output logic              ld_rotor_o,
    output logic [SLOT_W-1:0] ld_slot_o,
    output logic [SYM_W-1:0]  ld_val_o,
    output logic              plug_we_o,
    output logic [SYM_W-1:0]  plug_addr_o,
    output logic [SYM_W-1:0]  plug_data_o,
    output logic              enc_start_o,
    output logic [SYM_W-1:0]  enc_char_o,
    input  logic              enc_done_i,
    input  logic [SYM_W-1:0]  enc_result_i
);
    localparam int N_CNT  = 3;
    localparam int STEP_W = $clog2(N_SLOTS + 1);
    localparam logic [SYM_W-1:0] LET_MAX = SYM_W'(N_LETTERS - 1);
    localparam logic [SYM_W-1:0] ROT_MAX = SYM_W'(N_ROTOR_TYPES - 1);

    seq_state_e                   state;
    logic [STEP_W-1:0]            step;
    logic                         pend;
    logic [SYM_W-1:0]             paddr;
    logic                         seg_on;
    op_e                          dec_op;
    logic [SYM_W-1:0]             dec_data;
    logic                         dec_ok;
    logic                         acc;
    logic [N_CNT-1:0]             inc;
    logic                         cnt_clr;
    logic [N_CNT-1:0][SLOT_W-1:0] slot;
    logic [6:0]                   glyph;

    cmd_decode #(
        .SYM_W(SYM_W), .N_LETTERS(N_LETTERS), .N_ROTOR_TYPES(N_ROTOR_TYPES)
    ) dec_i (
        .word_i(cmd_word_i), .op_o(dec_op), .data_o(dec_data), .ok_o(dec_ok)
    );

    slot_counters #(.N_SLOTS(N_SLOTS), .N_CNT(N_CNT)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(inc), .slot_o(slot)
    );

    glyph_rom #(.SYM_W(SYM_W)) glyph_i (.sym_i(result_o), .seg_o(glyph));

    // Accept decision and counter increments for the three slot loads.
    always_comb begin
        acc     = (state == S_IDLE) && dec_ok;
        inc[0]  = acc && (dec_op == OP_POS);
        inc[1]  = acc && (dec_op == OP_RING);
        inc[2]  = acc && (dec_op == OP_ROTOR);
        cnt_clr = acc && (dec_op == OP_CLEAR);
    end

    assign ready_o = (state == S_IDLE);
    assign seg_o   = seg_on ? glyph : 7'h00;

    // Sequencer: init replay, command dispatch and encipher wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_INIT;
            step        <= '0;
            pend        <= 1'b0;
            paddr       <= '0;
            seg_on      <= 1'b0;
            result_o    <= '0;
            dp_clear_o  <= 1'b0;
            ld_pos_o    <= 1'b0;
            ld_ring_o   <= 1'b0;
            ld_rotor_o  <= 1'b0;
            ld_slot_o   <= '0;
            ld_val_o    <= '0;
            plug_we_o   <= 1'b0;
            plug_addr_o <= '0;
            plug_data_o <= '0;
            enc_start_o <= 1'b0;
            enc_char_o  <= '0;
        end else begin
            dp_clear_o  <= 1'b0;
            ld_pos_o    <= 1'b0;
            ld_ring_o   <= 1'b0;
            ld_rotor_o  <= 1'b0;
            plug_we_o   <= 1'b0;
            enc_start_o <= 1'b0;
            unique case (state)
                S_INIT: begin
                    if (step == '0) begin
                        dp_clear_o <= 1'b1;
                    end else begin
                        ld_rotor_o <= 1'b1;
                        ld_slot_o  <= SLOT_W'(step - STEP_W'(1));
                        ld_val_o   <= SYM_W'(step - STEP_W'(1));
                        if (step == STEP_W'(N_SLOTS))
                            state <= S_IDLE;
                    end
                    step <= step + 1'b1;
                end
                S_IDLE: begin
                    if (acc) begin
                        unique case (dec_op)
                            OP_POS: begin
                                ld_pos_o  <= 1'b1;
                                ld_slot_o <= slot[0];
                                ld_val_o  <= dec_data;
                            end
                            OP_RING: begin
                                ld_ring_o <= 1'b1;
                                ld_slot_o <= slot[1];
                                ld_val_o  <= dec_data;
                            end
                            OP_ROTOR: begin
                                ld_rotor_o <= 1'b1;
                                ld_slot_o  <= slot[2];
                                ld_val_o   <= dec_data;
                            end
                            OP_CLEAR: begin
                                dp_clear_o <= 1'b1;
                                step       <= STEP_W'(1);
                                state      <= S_INIT;
                                pend       <= 1'b0;
                                seg_on     <= 1'b0;
                                result_o   <= '0;
                            end
                            OP_ENC: begin
                                enc_start_o <= 1'b1;
                                enc_char_o  <= dec_data;
                                state       <= S_WAIT;
                            end
                            OP_PADDR: begin
                                pend  <= 1'b1;
                                paddr <= dec_data;
                            end
                            OP_PDATA: begin
                                if (pend) begin
                                    plug_we_o   <= 1'b1;
                                    plug_addr_o <= paddr;
                                    plug_data_o <= dec_data;
                                    pend        <= 1'b0;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                S_WAIT: begin
                    if (enc_done_i) begin
                        result_o <= enc_result_i;
                        seg_on   <= 1'b1;
                        state    <= S_IDLE;
                    end
                end
                default: state <= S_INIT;
            endcase
        end
    end

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dp_clear_o, ld_pos_o, ld_ring_o, ld_rotor_o, plug_we_o, enc_start_o}));
    a_r4_letter_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pos_o || ld_ring_o) |-> (ld_val_o <= LET_MAX));
    a_r4_rotor_range: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rotor_o |-> (ld_val_o <= ROT_MAX));
    a_r5_plug_range: assert property (@(posedge clk) disable iff (!rst_n)
        plug_we_o |-> (plug_addr_o <= LET_MAX && plug_data_o <= LET_MAX));
    a_r6_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        enc_start_o |-> !ready_o);
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == S_WAIT) && $past(enc_done_i)) |-> (result_o == $past(enc_result_i)));
    a_r7_quiet_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == S_WAIT) |-> !(ld_pos_o || ld_ring_o || ld_rotor_o || plug_we_o || enc_start_o || dp_clear_o));
endmodule

// File: tb/cipher_cmd_seq_tb_top.sv
module cipher_cmd_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_word = 8'h00;
    logic       enc_done = 1'b0;
    logic [4:0] enc_result = '0;
    logic       ready_o, dp_clear_o, ld_pos_o, ld_ring_o, ld_rotor_o, plug_we_o, enc_start_o;
    logic [4:0] result_o, ld_val_o, plug_addr_o, plug_data_o, enc_char_o;
    logic [6:0] seg_o;
    logic [1:0] ld_slot_o;
    logic [5:0] strb;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;
    int m_slot[3];
    bit m_pend;
    int m_paddr;
    int m_result;
    bit m_segon;

    always #4 clk = ~clk;

    cipher_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_word_i(cmd_word), .ready_o(ready_o),
        .result_o(result_o), .seg_o(seg_o), .dp_clear_o(dp_clear_o),
        .ld_pos_o(ld_pos_o), .ld_ring_o(ld_ring_o), .ld_rotor_o(ld_rotor_o),
        .ld_slot_o(ld_slot_o), .ld_val_o(ld_val_o), .plug_we_o(plug_we_o),
        .plug_addr_o(plug_addr_o), .plug_data_o(plug_data_o),
        .enc_start_o(enc_start_o), .enc_char_o(enc_char_o),
        .enc_done_i(enc_done), .enc_result_i(enc_result)
    );

    assign strb = {dp_clear_o, ld_pos_o, ld_ring_o, ld_rotor_o, plug_we_o, enc_start_o};

    function automatic int glyph(int c);
        case (c)
            0: return 'h77;  1: return 'h7C;  2: return 'h39;  3: return 'h5E;
            4: return 'h79;  5: return 'h71;  6: return 'h3D;  7: return 'h76;
            8: return 'h06;  9: return 'h1E; 10: return 'h75; 11: return 'h38;
            12: return 'h37; 13: return 'h54; 14: return 'h3F; 15: return 'h73;
            16: return 'h67; 17: return 'h50; 18: return 'h6D; 19: return 'h78;
            20: return 'h3E; 21: return 'h1C; 22: return 'h2A; 23: return 'h49;
            24: return 'h6E; 25: return 'h5B;
            default: return 0;
        endcase
    endfunction

    function automatic int dp_model(int c);
        return (c * 7 + 3) % 26;
    endfunction

    function automatic int exp_seg();
        return m_segon ? glyph(m_result) : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) m_slot[i] = 0;
        m_pend = 0; m_paddr = 0; m_result = 0; m_segon = 0;
    endtask

    // At the negedge where the clear pulse is due: check the replay (R2).
    task automatic check_init();
        chk("R2 clear strobe", strb, 6'b100000);
        chk("R2 ready low", ready_o, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 rotor default strobe", strb, 6'b000100);
            chk("R2 default slot", ld_slot_o, i);
            chk("R2 default value", ld_val_o, i);
            chk("R2 ready timing", ready_o, (i == 2) ? 1 : 0);
        end
        chk("R2 result cleared", result_o, 0);
        chk("R9 blank after reset", seg_o, 0);
        model_reset();
    endtask

    task automatic issue(int op, int data);
        bit legal;
        int k;
        int lat;
        while (!ready_o) @(negedge clk);
        cmd_word = {op[2:0], data[4:0]};
        @(negedge clk);
        cmd_word = 8'h00;
        legal = (op == 7) ? (data <= 4) : (data <= 25);
        case (op)
            0: begin
                chk("R8 nop no strobe", strb, 0);
                chk("R8 nop ready", ready_o, 1);
                chk("R8 nop display", seg_o, exp_seg());
            end
            1, 2, 7: begin
                k = (op == 1) ? 0 : (op == 2) ? 1 : 2;
                if (legal) begin
                    chk("R3 load strobe", strb, (op == 1) ? 6'b010000 : (op == 2) ? 6'b001000 : 6'b000100);
                    chk("R3 load slot", ld_slot_o, m_slot[k]);
                    chk("R3 load value", ld_val_o, data);
                    chk("R10 ready kept", ready_o, 1);
                    m_slot[k] = (m_slot[k] + 1) % 3;
                end else begin
                    chk("R4 range drop", strb, 0);
                end
            end
            3: check_init();
            4: begin
                if (legal) begin
                    chk("R6 start strobe", strb, 6'b000001);
                    chk("R6 start char", enc_char_o, data);
                    chk("R6 ready low", ready_o, 0);
                    lat = $urandom_range(1, 5);
                    for (int i = 0; i < lat; i++) begin
                        cmd_word = 8'($urandom_range(0, 255));
                        @(negedge clk);
                        chk("R7 busy no strobe", strb, 0);
                        chk("R7 busy ready", ready_o, 0);
                    end
                    enc_done = 1'b1;
                    enc_result = 5'(dp_model(data));
                    cmd_word = 8'($urandom_range(0, 255));
                    @(negedge clk);
                    enc_done = 1'b0;
                    cmd_word = 8'h00;
                    m_result = dp_model(data);
                    m_segon = 1;
                    chk("R6 ready back", ready_o, 1);
                    chk("R6 result", result_o, m_result);
                    chk("R9 glyph", seg_o, exp_seg());
                end else begin
                    chk("R4 encipher drop", strb, 0);
                    chk("R4 ready kept", ready_o, 1);
                    chk("R9 display kept", seg_o, exp_seg());
                end
            end
            5: begin
                chk("R5 address no strobe", strb, 0);
                if (legal) begin m_pend = 1; m_paddr = data; end
            end
            default: begin
                if (legal && m_pend) begin
                    chk("R5 plug strobe", strb, 6'b000010);
                    chk("R5 plug addr", plug_addr_o, m_paddr);
                    chk("R5 plug data", plug_data_o, data);
                    m_pend = 0;
                end else begin
                    chk("R5 no write", strb, 0);
                end
            end
        endcase
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R2 ready in reset", ready_o, 0);
        chk("R9 blank in reset", seg_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_init();
        // R9: blank before first result, even after loads
        issue(1, 3);
        chk("R9 blank before encipher", seg_o, 0);
        // R3: wrap of rotor counter, independence from position counter
        issue(7, 4); issue(7, 0); issue(7, 2); issue(7, 1);
        issue(2, 25); issue(1, 0);
        // R4: out-of-range operands
        issue(7, 5); issue(1, 26); issue(2, 31); issue(7, 3);
        // R5: data without address, then address/data, then data again
        issue(6, 4); issue(5, 13); issue(6, 0); issue(6, 9);
        issue(5, 30); issue(6, 2);
        // R8 / R1 no-op
        issue(0, 17);
        // R6 / R9 / R7
        issue(4, 0); issue(4, 25); issue(4, 26);
        // R2 via command, then check counters restart
        issue(3, 0); issue(2, 7); issue(7, 1);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            int d;
            op = $urandom_range(0, 7);
            d = ($urandom_range(0, 9) == 0) ? $urandom_range(26, 31) : $urandom_range(0, 25);
            if (op == 7 && $urandom_range(0, 1) == 1) d = $urandom_range(0, 6);
            issue(op, d);
        end
        finish_run();
    end
endmodule